// File: doc/BRIEF.md
# Interrupt Entry Bus Sequencer

This block moves a processor core from an accepted interrupt request to the first instruction of its handler. It watches for a point where the request may be taken. That point is either a completed instruction, or an interruptible block-move or multiply-accumulate instruction that it aborts on the spot. It then waits until the instruction queue can take a bus cycle, and drives a fixed chain of byte-wide bus cycles on its own synchronous bus. The chain reads the interrupt information word, pushes the return address and the old flags, and reads a three-byte handler vector.

On the way it loads the core's flag register twice: once to close interrupts, once to raise the priority level. It also loads the active stack pointer and finally the program counter, then reports completion with a one-cycle pulse. The core supplies the current flags, program counter and both stack pointers as inputs and acts on the load strobes. Hardware requests come from an external arbiter as a level. Software interrupt instructions raise a one-cycle request that carries the interrupt number.

Top module: `irq_entry_seq`

## Requirements
- R1: In the idle state, a software request (`sw_req`) starts a sequence in any cycle. A hardware request (`hw_req`) starts one only in a cycle where `insn_done` or `str_busy` is high. Software wins when both are present. Requests that arrive while a sequence runs are ignored.
- R2: `insn_suspend` is high, combinationally, in exactly the cycle where a hardware request is taken through `str_busy` without `insn_done`.
- R3: After the start cycle the bus stays idle until `fetch_ready` has been seen high. In the following cycle a single read of address 0 takes place. `flg_in` and `pc_in` are taken in the start cycle.
- R4: For a hardware request, the byte returned by the address-0 read carries the interrupt number in bits [4:0] and the requested level in bits [7:5]. In the next cycle `req_clr` pulses with that number on `req_clr_num`. Software requests produce no `req_clr`.
- R5: In the cycle after the address-0 read, `flg_wr` loads the captured flags with I (bit 6) and D (bit 1) cleared. U (bit 7) is also cleared, unless the request is software with number 32 to 63, in which case U keeps its value.
- R6: Four write cycles follow back to back, using SP = `usp_in` if the resulting U is 1, else `isp_in`. The writes are: SP-2 gets PC[7:0], SP-1 gets PC[15:8], SP-4 gets flags[7:0], and SP-3 gets {flags[15:12], PC[19:16]}. The flags here are the values captured at start. Addresses are 16-bit, wrap modulo 2^16 and are zero-extended on the bus.
- R7: The cycle after the last write asserts both `flg_wr` and `sp_wr`. The flag value is the R5 value with bits [14:12] replaced by the level from R4; software requests leave those bits unchanged. The stack pointer value is SP-4, and `sp_user` equals the resulting U.
- R8: Three reads follow at V, V+1 and V+2, where V = `vec_base` + 4 × number, modulo 2^20.
- R9: The next cycle asserts `pc_wr` and `done` for one cycle, with `pc_new` = {byte2[3:0], byte1, byte0}. The block is idle in the cycle after, and it can start again at once.
- R10: At most one of `bus_rd` and `bus_wr` is high. Neither is high while idle, while waiting, or in the two internal cycles. Reset leaves every strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_req | input | 1 | Hardware request pending from the arbiter |
| sw_req | input | 1 | Software interrupt instruction request, one cycle |
| sw_num | input | 6 | Number carried by the software request |
| insn_done | input | 1 | Current instruction completes this cycle |
| str_busy | input | 1 | Interruptible string or multiply-accumulate instruction running |
| insn_suspend | output | 1 | Abort the running interruptible instruction |
| fetch_ready | input | 1 | Instruction queue can accept a bus cycle |
| flg_in | input | 16 | Current flag register |
| pc_in | input | 20 | Return program counter |
| isp_in | input | 16 | Interrupt stack pointer |
| usp_in | input | 16 | User stack pointer |
| vec_base | input | 20 | Vector table base address |
| bus_addr | output | 20 | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, taken at the edge ending the read cycle |
| flg_wr | output | 1 | Flag register load |
| flg_new | output | 16 | Flag value to load |
| pc_wr | output | 1 | Program counter load |
| pc_new | output | 20 | Handler start address |
| sp_wr | output | 1 | Stack pointer load |
| sp_user | output | 1 | 1: load goes to the user stack pointer |
| sp_new | output | 16 | Stack pointer value to load |
| req_clr | output | 1 | Clear the request bit of the taken source |
| req_clr_num | output | 5 | Number of the source to clear |
| done | output | 1 | Sequence finished |

## Verification
Some properties are checked on every cycle: the exclusive strobes, the clearing of I and D in every flag load, the pairing of the pointer load with the preceding write, the consecutive vector addresses and the single-cycle completion pulse. Other behaviour shows only in the bench's scenarios: the exact order of stack offsets and the bytes placed there, whether U is kept for software numbers 32 to 63 or cleared for 31, which stack pointer is chosen, and the wrap of stack and vector addresses. The same holds for capture of flags and PC at start even after the inputs change, and for requests ignored while busy or outside an instruction boundary.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int ADDR_W      = 20;
  localparam int DATA_W      = 8;
  localparam int SP_W        = 16;
  localparam int FLG_W       = 16;
  localparam int NUM_W       = 6;
  localparam int INFO_NUM_W  = 5;
  localparam int LVL_W       = DATA_W - INFO_NUM_W;
  localparam int FLG_D       = 1;
  localparam int FLG_I       = 6;
  localparam int FLG_U       = 7;
  localparam int IPL_LO      = 12;
  localparam int FHI_LO      = 12;
  localparam int FHI_W       = FLG_W - FHI_LO;
  localparam int PC_HI_LO    = 2 * DATA_W;
  localparam int PC_HI_W     = ADDR_W - PC_HI_LO;
  localparam int SW_KEEP_MIN = 32;
  localparam int PUSH_N      = 4;
  localparam int VEC_N       = 3;
  localparam int VEC_STRIDE  = 2;
  localparam int STEP_W      = $clog2(PUSH_N);

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAITQ, ST_INFO, ST_FLAG, ST_PUSH, ST_IPL, ST_VEC, ST_LOAD
  } seq_state_e;

  // flags after entry: interrupts and single step closed, stack select maybe kept
  function automatic logic [FLG_W-1:0] entry_flags(input logic [FLG_W-1:0] f,
                                                   input logic keep_u);
    logic [FLG_W-1:0] r;
    r = f;
    r[FLG_I] = 1'b0;
    r[FLG_D] = 1'b0;
    if (!keep_u) r[FLG_U] = 1'b0;
    return r;
  endfunction

  function automatic logic [FLG_W-1:0] with_level(input logic [FLG_W-1:0] f,
                                                  input logic [LVL_W-1:0] l);
    logic [FLG_W-1:0] r;
    r = f;
    r[IPL_LO +: LVL_W] = l;
    return r;
  endfunction

  // stack write order is part of the behaviour: -2, -1, -4, -3
  function automatic logic [SP_W-1:0] push_offset(input logic [STEP_W-1:0] idx);
    case (idx)
      2'd0:    return SP_W'(2);
      2'd1:    return SP_W'(1);
      2'd2:    return SP_W'(4);
      default: return SP_W'(3);
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] push_byte(input logic [STEP_W-1:0] idx,
                                                  input logic [ADDR_W-1:0] pc,
                                                  input logic [DATA_W-1:0] flo,
                                                  input logic [FHI_W-1:0]  fhi);
    case (idx)
      2'd0:    return pc[DATA_W-1:0];
      2'd1:    return pc[2*DATA_W-1:DATA_W];
      2'd2:    return flo;
      default: return {fhi, pc[ADDR_W-1:PC_HI_LO]};
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] vec_first(input logic [ADDR_W-1:0] base,
                                                  input logic [NUM_W-1:0] num);
    return base + ({{(ADDR_W-NUM_W){1'b0}}, num} << VEC_STRIDE);
  endfunction

  function automatic logic [ADDR_W-1:0] vec_join(input logic [DATA_W-1:0]  b0,
                                                 input logic [DATA_W-1:0]  b1,
                                                 input logic [PC_HI_W-1:0] b2);
    return {b2, b1, b0};
  endfunction
endpackage

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_req,
  input  logic              sw_req,
  input  logic              insn_done,
  input  logic              str_busy,
  input  logic              fetch_ready,
  output seq_state_e        st,
  output logic [STEP_W-1:0] step,
  output logic              start,
  output logic              start_sw,
  output logic              suspend
);
  localparam logic [STEP_W-1:0] PUSH_LAST = STEP_W'(PUSH_N - 1);
  localparam logic [STEP_W-1:0] VEC_LAST  = STEP_W'(VEC_N - 1);

  seq_state_e st_nx;
  logic       idle;
  logic       hw_take;
  logic       step_last;

  assign idle      = (st == ST_IDLE);
  assign hw_take   = hw_req && (insn_done || str_busy);
  assign start_sw  = idle && sw_req;
  assign start     = idle && (sw_req || hw_take);
  assign suspend   = idle && !sw_req && hw_req && str_busy && !insn_done;
  assign step_last = ((st == ST_PUSH) && (step == PUSH_LAST)) ||
                     ((st == ST_VEC)  && (step == VEC_LAST));

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:  if (start) st_nx = ST_WAITQ;
      ST_WAITQ: if (fetch_ready) st_nx = ST_INFO;
      ST_INFO:  st_nx = ST_FLAG;
      ST_FLAG:  st_nx = ST_PUSH;
      ST_PUSH:  if (step_last) st_nx = ST_IPL;
      ST_IPL:   st_nx = ST_VEC;
      ST_VEC:   if (step_last) st_nx = ST_LOAD;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      step <= '0;
    end else begin
      st <= st_nx;
      if (((st == ST_PUSH) || (st == ST_VEC)) && !step_last) step <= step + 1'b1;
      else step <= '0;
    end
  end

  // R3: waiting is left only after the queue is ready
  a_r3_wait_for_queue: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAITQ && !fetch_ready) |=> (st == ST_WAITQ));
endmodule

// File: rtl/irq_entry_dp.sv
module irq_entry_dp
  import irq_entry_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  seq_state_e            st,
  input  logic [STEP_W-1:0]     step,
  input  logic                  start,
  input  logic                  start_sw,
  input  logic [NUM_W-1:0]      sw_num,
  input  logic [FLG_W-1:0]      flg_in,
  input  logic [ADDR_W-1:0]     pc_in,
  input  logic [SP_W-1:0]       isp_in,
  input  logic [SP_W-1:0]       usp_in,
  input  logic [ADDR_W-1:0]     vec_base,
  input  logic [DATA_W-1:0]     bus_rdata,
  output logic                  is_sw,
  output logic [INFO_NUM_W-1:0] hw_num,
  output logic [FLG_W-1:0]      flg_entry,
  output logic [FLG_W-1:0]      flg_ipl,
  output logic [ADDR_W-1:0]     push_addr,
  output logic [DATA_W-1:0]     push_data,
  output logic [ADDR_W-1:0]     vec_addr,
  output logic [SP_W-1:0]       sp_after,
  output logic                  sp_user,
  output logic [ADDR_W-1:0]     pc_vec
);
  logic [FLG_W-1:0]   tmp_flg;
  logic [ADDR_W-1:0]  ret_pc;
  logic [NUM_W-1:0]   num;
  logic [LVL_W-1:0]   lvl;
  logic [SP_W-1:0]    sp_base;
  logic [DATA_W-1:0]  vb0, vb1;
  logic [PC_HI_W-1:0] vb2;
  logic               keep_u;
  logic [SP_W-1:0]    slot;

  assign keep_u    = is_sw && (num >= NUM_W'(SW_KEEP_MIN));
  assign flg_entry = entry_flags(tmp_flg, keep_u);
  assign flg_ipl   = is_sw ? flg_entry : with_level(flg_entry, lvl);
  assign slot      = sp_base - push_offset(step);
  assign push_addr = {{(ADDR_W-SP_W){1'b0}}, slot};
  assign push_data = push_byte(step, ret_pc, tmp_flg[DATA_W-1:0], tmp_flg[FLG_W-1:FHI_LO]);
  assign vec_addr  = vec_first(vec_base, num) + ADDR_W'(step);
  assign sp_after  = sp_base - SP_W'(PUSH_N);
  assign pc_vec    = vec_join(vb0, vb1, vb2);
  assign hw_num    = num[INFO_NUM_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmp_flg <= '0;
      ret_pc  <= '0;
      is_sw   <= 1'b0;
      num     <= '0;
      lvl     <= '0;
      sp_base <= '0;
      sp_user <= 1'b0;
      vb0     <= '0;
      vb1     <= '0;
      vb2     <= '0;
    end else begin
      if (start) begin
        tmp_flg <= flg_in;
        ret_pc  <= pc_in;
        is_sw   <= start_sw;
        num     <= start_sw ? sw_num : '0;
        lvl     <= '0;
      end
      if (st == ST_INFO && !is_sw) begin
        num <= NUM_W'(bus_rdata[INFO_NUM_W-1:0]);
        lvl <= bus_rdata[DATA_W-1 -: LVL_W];
      end
      if (st == ST_FLAG) begin
        sp_base <= flg_entry[FLG_U] ? usp_in : isp_in;
        sp_user <= flg_entry[FLG_U];
      end
      if (st == ST_VEC) begin
        case (step)
          2'd0:    vb0 <= bus_rdata;
          2'd1:    vb1 <= bus_rdata;
          default: vb2 <= bus_rdata[PC_HI_W-1:0];
        endcase
      end
    end
  end

  // R5: a software number below the keep range never preserves U
  a_r5_low_sw_clears_u: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FLAG && is_sw && !num[NUM_W-1]) |-> !flg_entry[FLG_U]);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hw_req,
  input  logic                  sw_req,
  input  logic [NUM_W-1:0]      sw_num,
  input  logic                  insn_done,
  input  logic                  str_busy,
  output logic                  insn_suspend,
  input  logic                  fetch_ready,
  input  logic [FLG_W-1:0]      flg_in,
  input  logic [ADDR_W-1:0]     pc_in,
  input  logic [SP_W-1:0]       isp_in,
  input  logic [SP_W-1:0]       usp_in,
  input  logic [ADDR_W-1:0]     vec_base,
  output logic [ADDR_W-1:0]     bus_addr,
  output logic                  bus_rd,
  output logic                  bus_wr,
  output logic [DATA_W-1:0]     bus_wdata,
  input  logic [DATA_W-1:0]     bus_rdata,
  output logic                  flg_wr,
  output logic [FLG_W-1:0]      flg_new,
  output logic                  pc_wr,
  output logic [ADDR_W-1:0]     pc_new,
  output logic                  sp_wr,
  output logic                  sp_user,
  output logic [SP_W-1:0]       sp_new,
  output logic                  req_clr,
  output logic [INFO_NUM_W-1:0] req_clr_num,
  output logic                  done
);
  seq_state_e        st;
  logic [STEP_W-1:0] step;
  logic              start, start_sw;
  logic              is_sw;
  logic [FLG_W-1:0]  flg_entry, flg_ipl;
  logic [ADDR_W-1:0] push_addr, vec_addr;
  logic [DATA_W-1:0] push_data;

  // named events
  logic info_cycle, flag_cycle, push_cycle, ipl_cycle, vec_cycle, load_cycle;
  assign info_cycle = (st == ST_INFO);
  assign flag_cycle = (st == ST_FLAG);
  assign push_cycle = (st == ST_PUSH);
  assign ipl_cycle  = (st == ST_IPL);
  assign vec_cycle  = (st == ST_VEC);
  assign load_cycle = (st == ST_LOAD);

  irq_entry_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .hw_req     (hw_req),
    .sw_req     (sw_req),
    .insn_done  (insn_done),
    .str_busy   (str_busy),
    .fetch_ready(fetch_ready),
    .st         (st),
    .step       (step),
    .start      (start),
    .start_sw   (start_sw),
    .suspend    (insn_suspend)
  );

  irq_entry_dp u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .step      (step),
    .start     (start),
    .start_sw  (start_sw),
    .sw_num    (sw_num),
    .flg_in    (flg_in),
    .pc_in     (pc_in),
    .isp_in    (isp_in),
    .usp_in    (usp_in),
    .vec_base  (vec_base),
    .bus_rdata (bus_rdata),
    .is_sw     (is_sw),
    .hw_num    (req_clr_num),
    .flg_entry (flg_entry),
    .flg_ipl   (flg_ipl),
    .push_addr (push_addr),
    .push_data (push_data),
    .vec_addr  (vec_addr),
    .sp_after  (sp_new),
    .sp_user   (sp_user),
    .pc_vec    (pc_new)
  );

  assign bus_rd    = info_cycle || vec_cycle;
  assign bus_wr    = push_cycle;
  assign bus_wdata = push_cycle ? push_data : '0;

  always_comb begin
    bus_addr = '0;
    if (push_cycle)     bus_addr = push_addr;
    else if (vec_cycle) bus_addr = vec_addr;
  end

  assign flg_wr  = flag_cycle || ipl_cycle;
  assign flg_new = ipl_cycle ? flg_ipl : flg_entry;
  assign sp_wr   = ipl_cycle;
  assign req_clr = flag_cycle && !is_sw;
  assign pc_wr   = load_cycle;
  assign done    = load_cycle;

  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  a_r4_clear_after_info: assert property (@(posedge clk) disable iff (!rst_n)
    req_clr |-> ($past(bus_rd) && ($past(bus_addr) == '0) && flg_wr));

  a_r5_flags_closed: assert property (@(posedge clk) disable iff (!rst_n)
    flg_wr |-> (!flg_new[FLG_I] && !flg_new[FLG_D]));

  a_r6_push_after_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !$past(bus_wr)) |-> $past(flg_wr));

  a_r6_stack_low_space: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> (bus_addr[ADDR_W-1:SP_W] == '0));

  a_r7_sp_after_writes: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wr |-> (flg_wr && $past(bus_wr)));

  a_r8_vec_consecutive: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && $past(bus_rd) && ($past(bus_addr) != '0)) |->
      (bus_addr == $past(bus_addr) + ADDR_W'(1)));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_pc_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr |-> (done && $past(bus_rd)));
endmodule

// File: tb/irq_entry_seq_test.sv
`timescale 1ns/1ps
module irq_entry_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_req = 1'b0, sw_req = 1'b0, insn_done = 1'b0, str_busy = 1'b0;
  logic        fetch_ready = 1'b0;
  logic [5:0]  sw_num = '0;
  logic [15:0] flg_in = '0, isp_in = '0, usp_in = '0;
  logic [19:0] pc_in = '0, vec_base = '0;
  logic        insn_suspend, bus_rd, bus_wr, flg_wr, pc_wr, sp_wr, sp_user, req_clr, done;
  logic [19:0] bus_addr, pc_new;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [15:0] flg_new, sp_new;
  logic [4:0]  req_clr_num;
  logic [7:0]  info_byte = '0;
  int          total = 0, fails = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [19:0] a, input logic [7:0] info);
    if (a == 20'h0) return info;
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[3:0]} ^ 8'h3c;
  endfunction
  assign bus_rdata = mem_byte(bus_addr, info_byte);

  irq_entry_seq uut (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .sw_req(sw_req), .sw_num(sw_num),
    .insn_done(insn_done), .str_busy(str_busy), .insn_suspend(insn_suspend),
    .fetch_ready(fetch_ready), .flg_in(flg_in), .pc_in(pc_in), .isp_in(isp_in),
    .usp_in(usp_in), .vec_base(vec_base), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flg_wr(flg_wr),
    .flg_new(flg_new), .pc_wr(pc_wr), .pc_new(pc_new), .sp_wr(sp_wr), .sp_user(sp_user),
    .sp_new(sp_new), .req_clr(req_clr), .req_clr_num(req_clr_num), .done(done));

  localparam logic [7:0] S_RD = 8'h80, S_WR = 8'h40, S_FLG = 8'h20, S_PC = 8'h10,
                         S_SP = 8'h08, S_CLR = 8'h04, S_DONE = 8'h02, S_SUS = 8'h01;

  function automatic logic [7:0] strobes();
    return {bus_rd, bus_wr, flg_wr, pc_wr, sp_wr, req_clr, done, insn_suspend};
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  // bench-side statement of R5/R7 flag rules
  function automatic logic [15:0] exp_entry(input logic [15:0] f, input bit keep);
    logic [15:0] r;
    r = f & ~16'h0042;
    if (!keep) r = r & ~16'h0080;
    return r;
  endfunction

  task automatic run_entry(input bit sw, input logic [5:0] swn, input bit via_str,
                           input int qwait, input logic [15:0] f, input logic [19:0] pc,
                           input logic [15:0] isp, input logic [15:0] usp,
                           input logic [19:0] base, input logic [7:0] info, input int tail);
    logic [5:0]  num;
    bit          keep, newu;
    logic [15:0] sp, f1, f2;
    logic [15:0] offs [4];
    logic [7:0]  data [4];
    logic [19:0] v;
    logic [19:0] exp_pc;
    num  = sw ? swn : {1'b0, info[4:0]};
    keep = sw && (swn >= 6'd32);
    f1   = exp_entry(f, keep);
    newu = f1[7];
    sp   = newu ? usp : isp;
    f2   = sw ? f1 : {f1[15], info[7:5], f1[11:0]};
    offs = '{16'd2, 16'd1, 16'd4, 16'd3};
    data = '{pc[7:0], pc[15:8], f[7:0], {f[15:12], pc[19:16]}};
    v    = base + {12'h0, num, 2'b00};
    exp_pc = {mem_byte(v + 20'd2, info)[3:0], mem_byte(v + 20'd1, info), mem_byte(v, info)};

    info_byte = info; isp_in = isp; usp_in = usp; vec_base = base;
    flg_in = f; pc_in = pc; fetch_ready = (qwait == 0);
    if (sw) begin sw_req = 1'b1; sw_num = swn; end
    else begin hw_req = 1'b1; insn_done = !via_str; str_busy = via_str; end
    #1 chk("R2 suspend at start", {31'h0, insn_suspend}, {31'h0, !sw && via_str});
    @(negedge clk);
    sw_req = 1'b0; insn_done = 1'b0; str_busy = 1'b0;
    flg_in = ~f; pc_in = ~pc;
    chk("R3 idle while waiting", {24'h0, strobes()}, 32'h0);
    for (int i = 1; i < qwait; i++) begin
      @(negedge clk);
      chk("R3 idle while waiting", {24'h0, strobes()}, 32'h0);
    end
    fetch_ready = 1'b1;
    @(negedge clk);
    chk("R3 info read strobe", {24'h0, strobes()}, {24'h0, S_RD});
    chk("R3 info read addr", {12'h0, bus_addr}, 32'h0);
    @(negedge clk);
    chk("R4/R5 flag cycle strobes", {24'h0, strobes()}, {24'h0, sw ? S_FLG : (S_FLG | S_CLR)});
    chk("R5 entry flags", {16'h0, flg_new}, {16'h0, f1});
    if (!sw) chk("R4 clear number", {27'h0, req_clr_num}, {27'h0, info[4:0]});
    hw_req = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (k == 0) begin sw_req = 1'b1; sw_num = 6'd40; end  // R1: ignored while busy
      else sw_req = 1'b0;
      chk("R6 push strobe", {24'h0, strobes()}, {24'h0, S_WR});
      chk("R6 push addr", {12'h0, bus_addr}, {16'h0, sp - offs[k]});
      chk("R6 push data", {24'h0, bus_wdata}, {24'h0, data[k]});
    end
    @(negedge clk);
    sw_req = 1'b0;
    chk("R7 level cycle strobes", {24'h0, strobes()}, {24'h0, S_FLG | S_SP});
    chk("R7 level flags", {16'h0, flg_new}, {16'h0, f2});
    chk("R7 new sp", {15'h0, sp_user, sp_new}, {15'h0, newu, sp - 16'd4});
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 vector strobe", {24'h0, strobes()}, {24'h0, S_RD});
      chk("R8 vector addr", {12'h0, bus_addr}, {12'h0, v + 20'(k)});
    end
    @(negedge clk);
    chk("R9 load strobes", {24'h0, strobes()}, {24'h0, S_PC | S_DONE});
    chk("R9 handler address", {12'h0, pc_new}, {12'h0, exp_pc});
    @(negedge clk);
    fetch_ready = 1'b0;
    chk("R9 back to idle", {24'h0, strobes()}, 32'h0);
    fetch_ready = 1'b1;
    for (int t = 0; t < tail; t++) begin
      @(negedge clk);
      chk("R1 busy request not taken", {24'h0, strobes()}, 32'h0);
    end
    fetch_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R10 reset strobes", {24'h0, strobes()}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle after reset", {24'h0, strobes()}, 32'h0);

    // R1: hardware request outside a boundary is not taken
    hw_req = 1'b1; fetch_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      #1 chk("R1 no boundary no start", {24'h0, strobes()}, 32'h0);
      @(negedge clk);
    end
    hw_req = 1'b0; fetch_ready = 1'b0;

    // R1: software wins over hardware in the same cycle
    hw_req = 1'b1; insn_done = 1'b1;
    run_entry(1'b1, 6'd5, 1'b0, 0, 16'h70c2, 20'h12345, 16'h0800, 16'h4400, 20'h0ff00, 8'hff, 1);
    chk("R1 hw left pending", {31'h0, hw_req}, 32'h0);

    // R5/R6: software 32 keeps U=1 and uses user stack
    run_entry(1'b1, 6'd32, 1'b0, 2, 16'h30ff, 20'habcde, 16'h1000, 16'h2000, 20'h40000, 8'h00, 0);
    // software 31 clears U, interrupt stack
    run_entry(1'b1, 6'd31, 1'b0, 0, 16'h00c2, 20'h00001, 16'h1000, 16'h2000, 20'h40000, 8'h00, 0);
    // software 63 with U=0
    run_entry(1'b1, 6'd63, 1'b0, 1, 16'h5042, 20'hfffff, 16'h0400, 16'h0600, 20'hfff00, 8'h00, 2);
    // R2: hardware through a suspended string instruction
    run_entry(1'b0, 6'd0, 1'b1, 3, 16'h7fff, 20'h54321, 16'h3000, 16'h5000, 20'h10000, 8'hb7, 1);
    // R6: stack wrap below zero
    run_entry(1'b0, 6'd0, 1'b0, 0, 16'h00ff, 20'h9a5c3, 16'h0002, 16'h8000, 20'h20000, 8'h41, 1);
    // R8: vector address wrap at the top of the space
    run_entry(1'b0, 6'd0, 1'b0, 6, 16'hffff, 20'h00000, 16'hffff, 16'h0000, 20'hffff8, 8'he3, 0);

    for (int n = 0; n < 40; n++) begin
      bit sw;
      sw = ($urandom % 3) == 0;
      run_entry(sw, 6'($urandom), 1'($urandom), int'($urandom % 5), 16'($urandom),
                20'($urandom), 16'($urandom), 16'($urandom), 20'($urandom),
                8'($urandom), int'($urandom % 3));
    end
    report();
    $finish;
  end
endmodule